// File: doc/BRIEF.md
# Partitioned Inter-Processor Interrupt Controller

This block lets software running on any core signal any other set of cores. Each core owns a sixteen-bit pending-cause word. A bank of sixteen "raise" addresses, one per cause bit, lets one register write post the same cause to any subset of cores. A per-core acknowledge address clears causes with write-one-to-clear semantics.

The sixteen causes are folded into four fixed classes of unequal size. A partition register steers each class onto one of three interrupt pins per core, or switches the class off. Pins are driven combinationally from the registered state, so a write becomes visible on the pins in the cycle after the clock edge that captured it. Reads are combinational from the read address.

Top module: `ipi_part_ctrl`

## Requirements
- R1: While reset is asserted and after its release, every cause word, the partition register and every pin read as zero until a write arrives.
- R2: A write of value v to address 0x140+k (k = 0..15) sets cause bit k in each core c for which v[c] is 1. All other bits and all other cores are left unchanged.
- R3: A write of value v to address 0x100+c clears cause bits of core c wherever v[15:0] has a 1. All other bits are left unchanged.
- R4: A read at 0x100+c returns core c's cause word in bits [15:0] with zeros above it. A read at 0x190 returns the partition register in bits [7:0] with zeros above it.
- R5: Causes form four classes: class 0 is bit 0, class 1 is bits 3..1, class 2 is bits 7..4 and class 3 is bits 15..8. A class is active when any of its bits is set.
- R6: The partition register at 0x190 holds a 2-bit pin selector per class at bits [1:0], [3:2], [5:4] and [7:6], for classes 0 to 3. Pin p of core c (output bit 3c+p) is the OR of the active classes whose selector equals p.
- R7: A selector value of 3 removes its class from every pin.
- R8: Data bits of a raise write that name cores at or beyond NUM_CORES have no effect. Clear writes to absent cores have no effect. Reads of absent cores or unmapped addresses return zero.
- R9: When no write is presented, cause words and partition register hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| ipi_pins | output | 3*NUM_CORES | Interrupt pins, core c at bits [3c+2:3c] |

## Verification
The checker checks, on every cycle, that a raise lands in each targeted core and that an acknowledge leaves no acknowledged bit set. It also checks that idle cycles leave all state untouched, that an all-disabled partition keeps every pin low, and that a core with no pending cause drives no pin. Only the directed scenarios can show the exact pin chosen for each class under a mixed partition. The same holds for zero reads of absent cores and unmapped addresses, for the harmlessness of high data bits, and for the read-back layout.

// File: rtl/ipi_part_pkg.sv
package ipi_part_pkg;
   localparam int unsigned CAUSE_W   = 16;
   localparam int unsigned CLASSES   = 4;
   localparam int unsigned PINS      = 3;
   localparam int unsigned SEL_W     = 2;
   localparam int unsigned PART_W    = CLASSES * SEL_W;
   localparam int unsigned CLR_BASE  = 32'h100;
   localparam int unsigned SET_BASE  = 32'h140;
   localparam int unsigned PART_ADDR = 32'h190;

   function automatic logic [CLASSES-1:0] class_active(input logic [CAUSE_W-1:0] c);
      return {|c[15:8], |c[7:4], |c[3:1], c[0]};
   endfunction
endpackage

// File: rtl/ipi_addr_dec.sv
module ipi_addr_dec
   import ipi_part_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned ADDR_W    = 10
)(
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   output logic [CAUSE_W-1:0]   set_sel,
   output logic [NUM_CORES-1:0] clr_hit,
   output logic                 part_hit
);
   localparam logic [ADDR_W-1:0] SET_A  = ADDR_W'(SET_BASE);
   localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_BASE);
   localparam logic [ADDR_W-1:0] PART_A = ADDR_W'(PART_ADDR);

   for (genvar k = 0; k < CAUSE_W; k++) begin : g_set
      assign set_sel[k] = wr_en && (wr_addr == SET_A + ADDR_W'(k));
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_clr
      assign clr_hit[c] = wr_en && (wr_addr == CLR_A + ADDR_W'(c));
   end

   assign part_hit = wr_en && (wr_addr == PART_A);
endmodule

// File: rtl/ipi_cause_bank.sv
module ipi_cause_bank
   import ipi_part_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4
)(
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [CAUSE_W-1:0]                  set_sel,
   input  logic [NUM_CORES-1:0]                set_cores,
   input  logic [NUM_CORES-1:0]                clr_hit,
   input  logic [CAUSE_W-1:0]                  clr_bits,
   output logic [NUM_CORES-1:0][CAUSE_W-1:0]   cause_q
);
   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic [CAUSE_W-1:0] q;
      logic [CAUSE_W-1:0] set_mask;
      logic [CAUSE_W-1:0] clr_mask;

      always_comb begin
         set_mask = set_cores[c] ? set_sel  : '0;
         clr_mask = clr_hit[c]   ? clr_bits : '0;
      end

      // acknowledge wins over a raise of the same bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= (q | set_mask) & ~clr_mask;
      end

      assign cause_q[c] = q;
   end
endmodule

// File: rtl/ipi_pin_map.sv
module ipi_pin_map
   import ipi_part_pkg::*;
(
   input  logic [CAUSE_W-1:0] cause,
   input  logic [PART_W-1:0]  part,
   output logic [PINS-1:0]    pins
);
   logic [CLASSES-1:0] act;

   always_comb begin
      act  = class_active(cause);
      pins = '0;
      for (int p = 0; p < PINS; p++) begin
         for (int g = 0; g < CLASSES; g++) begin
            if (act[g] && (part[g*SEL_W +: SEL_W] == SEL_W'(p))) pins[p] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/ipi_part_ctrl.sv
module ipi_part_ctrl
   import ipi_part_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned ADDR_W    = 10,
   parameter int unsigned DATA_W    = 32
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [DATA_W-1:0]         wr_data,
   input  logic [ADDR_W-1:0]         rd_addr,
   output logic [DATA_W-1:0]         rd_data,
   output logic [PINS*NUM_CORES-1:0] ipi_pins
);
   localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_BASE);
   localparam logic [ADDR_W-1:0] PART_A = ADDR_W'(PART_ADDR);

   if (NUM_CORES < 1 || NUM_CORES > 32) begin : g_bad_cores
      $error("ipi_part_ctrl: NUM_CORES must be 1..32");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("ipi_part_ctrl: ADDR_W must reach the partition address");
   end
   if (DATA_W < CAUSE_W || DATA_W < NUM_CORES) begin : g_bad_data
      $error("ipi_part_ctrl: DATA_W too narrow");
   end

   logic [CAUSE_W-1:0]                set_sel;
   logic [NUM_CORES-1:0]              clr_hit;
   logic                              part_hit;
   logic [NUM_CORES-1:0][CAUSE_W-1:0] cause_q;
   logic [PART_W-1:0]                 part_q;
   logic                              unused_wdata_bits;

   assign unused_wdata_bits = ^wr_data;

   ipi_addr_dec #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_dec (
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .set_sel  (set_sel),
      .clr_hit  (clr_hit),
      .part_hit (part_hit)
   );

   ipi_cause_bank #(.NUM_CORES(NUM_CORES)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_sel   (set_sel),
      .set_cores (wr_data[NUM_CORES-1:0]),
      .clr_hit   (clr_hit),
      .clr_bits  (wr_data[CAUSE_W-1:0]),
      .cause_q   (cause_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        part_q <= '0;
      else if (part_hit) part_q <= wr_data[PART_W-1:0];
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_pins
      ipi_pin_map u_map (
         .cause (cause_q[c]),
         .part  (part_q),
         .pins  (ipi_pins[c*PINS +: PINS])
      );
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == PART_A) rd_data = DATA_W'(part_q);
      for (int c = 0; c < NUM_CORES; c++) begin
         if (rd_addr == CLR_A + ADDR_W'(c)) rd_data = DATA_W'(cause_q[c]);
      end
   end
endmodule

// File: rtl/ipi_part_ctrl_chk.sv
module ipi_part_ctrl_chk
   import ipi_part_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned ADDR_W    = 10,
   parameter int unsigned DATA_W    = 32
)(
   input logic                              clk,
   input logic                              rst_n,
   input logic                              wr_en,
   input logic [ADDR_W-1:0]                 wr_addr,
   input logic [DATA_W-1:0]                 wr_data,
   input logic [PINS*NUM_CORES-1:0]         ipi_pins,
   input logic [NUM_CORES-1:0][CAUSE_W-1:0] cause_q,
   input logic [PART_W-1:0]                 part_q
);
   localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_BASE);
   localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_BASE);

   logic [CAUSE_W-1:0] chk_raise;
   logic               unused_chk_data;
   assign unused_chk_data = ^wr_data;

   always_comb begin
      chk_raise = '0;
      for (int k = 0; k < CAUSE_W; k++)
         if (wr_en && wr_addr == SET_A + ADDR_W'(k)) chk_raise[k] = 1'b1;
   end

   assert_reset_clears_R1: assert property (@(posedge clk)
      !rst_n |=> (cause_q == '0 && part_q == '0));

   assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(cause_q) && $stable(part_q)));

   assert_all_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (part_q == '1) |-> (ipi_pins == '0));

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      assert_raise_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_data[c] && chk_raise != '0) |=> ((cause_q[c] & $past(chk_raise)) == $past(chk_raise)));

      assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == CLR_A + ADDR_W'(c)) |=> ((cause_q[c] & $past(wr_data[CAUSE_W-1:0])) == '0));

      assert_quiet_core_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (cause_q[c] == '0) |-> (ipi_pins[c*PINS +: PINS] == '0));
   end
endmodule

bind ipi_part_ctrl ipi_part_ctrl_chk #(
   .NUM_CORES (NUM_CORES),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .ipi_pins (ipi_pins),
   .cause_q  (cause_q),
   .part_q   (part_q)
);

// File: tb/ipi_part_ctrl_test.sv
module ipi_part_ctrl_test;
   localparam int NC = 4;
   localparam int AW = 10;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic [3*NC-1:0] ipi_pins;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [15:0] exp_cause [NC];
   logic [7:0]  exp_part;

   always #5 clk = ~clk;

   ipi_part_ctrl #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ipi_pins(ipi_pins)
   );

   function automatic logic [2:0] model_pins(input logic [15:0] c, input logic [7:0] p);
      logic [3:0] act;
      logic [2:0] r;
      act = {c[15:8] != 0, c[7:4] != 0, c[3:1] != 0, c[0]};
      r = '0;
      for (int g = 0; g < 4; g++) begin
         int sel;
         sel = int'(p[2*g +: 2]);
         if (act[g] && sel < 3) r[sel] = 1'b1;
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input int addr, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_read(input int addr, output logic [31:0] data);
      rd_addr = AW'(addr);
      #1;
      data = rd_data;
   endtask

   task automatic compare_all(input string req);
      logic [31:0] v;
      for (int c = 0; c < NC; c++) begin
         reg_read('h100 + c, v);
         check(v == {16'h0, exp_cause[c]}, req, v, {16'h0, exp_cause[c]});
         check(ipi_pins[3*c +: 3] == model_pins(exp_cause[c], exp_part), req,
               32'(ipi_pins[3*c +: 3]), 32'(model_pins(exp_cause[c], exp_part)));
      end
      reg_read('h190, v);
      check(v == {24'h0, exp_part}, req, v, {24'h0, exp_part});
   endtask

   task automatic t_reset;
      for (int c = 0; c < NC; c++) exp_cause[c] = '0;
      exp_part = '0;
      #1;
      check(ipi_pins == '0, "R1 pins in reset", 32'(ipi_pins), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R1");
   endtask

   task automatic t_raise;
      reg_write('h140 + 3, 32'h0000_0005);
      exp_cause[0][3] = 1'b1; exp_cause[2][3] = 1'b1;
      compare_all("R2 raise bit3 cores0,2");
      reg_write('h140 + 15, 32'h0000_000F);
      for (int c = 0; c < NC; c++) exp_cause[c][15] = 1'b1;
      compare_all("R2 raise bit15 all");
      reg_write('h140 + 0, 32'h0000_0002);
      exp_cause[1][0] = 1'b1;
      compare_all("R2 raise bit0 core1");
   endtask

   task automatic t_ack;
      reg_write('h100 + 2, 32'h0000_8000);
      exp_cause[2][15] = 1'b0;
      compare_all("R3 ack bit15 core2");
      reg_write('h100 + 0, 32'hFFFF_FFFF);
      exp_cause[0] = '0;
      compare_all("R3 ack all core0");
      reg_write('h100 + 1, 32'h0000_0000);
      compare_all("R3 zero ack no change");
   endtask

   task automatic t_classes;
      for (int c = 0; c < NC; c++) begin
         reg_write('h100 + c, 32'h0000_FFFF);
         exp_cause[c] = '0;
      end
      reg_write('h190, 32'h0000_00C6);   // c0->2, c1->1, c2->0, c3 off
      exp_part = 8'hC6;
      reg_write('h140 + 0, 32'h1);  exp_cause[0][0] = 1'b1;
      reg_write('h140 + 2, 32'h2);  exp_cause[1][2] = 1'b1;
      reg_write('h140 + 5, 32'h4);  exp_cause[2][5] = 1'b1;
      reg_write('h140 + 9, 32'h8);  exp_cause[3][9] = 1'b1;
      compare_all("R5 R6 mixed partition");
      check(ipi_pins == 12'b000_001_010_100, "R6 pin layout", 32'(ipi_pins), 32'b000_001_010_100);
      reg_write('h190, 32'h0000_0000);
      exp_part = 8'h00;
      compare_all("R6 all classes on pin0");
      check(ipi_pins == 12'b001_001_001_001, "R6 pin0 all", 32'(ipi_pins), 32'b001_001_001_001);
   endtask

   task automatic t_disable;
      reg_write('h190, 32'h0000_00FF);
      exp_part = 8'hFF;
      compare_all("R7 all off");
      check(ipi_pins == '0, "R7 pins low", 32'(ipi_pins), 0);
      reg_write('h190, 32'h0000_003F);   // only class 3 on pin0
      exp_part = 8'h3F;
      compare_all("R7 partial off");
   endtask

   task automatic t_absent;
      logic [31:0] v;
      reg_write('h140 + 6, 32'hFFFF_FFF0);
      compare_all("R8 high core bits ignored");
      reg_write('h100 + NC, 32'hFFFF_FFFF);
      compare_all("R8 absent ack ignored");
      reg_read('h100 + NC, v);
      check(v == 0, "R8 absent core read", v, 0);
      reg_read('h150, v);
      check(v == 0, "R8 unmapped read", v, 0);
      reg_read('h190, v);
      check(v == {24'h0, exp_part}, "R4 partition read", v, {24'h0, exp_part});
   endtask

   task automatic t_idle;
      repeat (5) @(negedge clk);
      compare_all("R9 idle holds");
   endtask

   initial begin
      t_reset();
      t_raise();
      t_ack();
      t_classes();
      t_disable();
      t_absent();
      t_idle();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule